// File: doc/BRIEF.md
# Parallel-Prefix Population Counter

This block reports how many bits are set in a 64-bit word. It treats the word as a row of small fields and doubles the field width at each stage. Each stage merges neighbouring counts with masked shifts and adds, so every field of the word is updated at once.

The first stage turns each bit pair into a 2-bit count with one subtraction and one mask. The next stage builds 4-bit counts. The third stage builds 8-bit counts and masks once, after the add. A last reduction then sums the eight byte counts into one total. The parameter `USE_MUL` picks how that last reduction is done:

- `USE_MUL = 0` uses three shift-and-add steps.
- `USE_MUL = 1` multiplies the byte counts by a constant with 0x01 in every byte and takes the top byte of the product.

The parameter `PIPE` sets the latency:

- `PIPE = 0` gives a purely combinational path.
- `PIPE = 1` places one register after the byte-count stage.

A valid strobe travels alongside the data with the same latency.

Top module: `swar_popcount`

## Requirements
- R1: When `out_valid` is high, `out_count` equals the number of 1 bits in the `in_data` word that was accepted with the matching `in_valid`. The count is an unsigned 7-bit number in the range 0 to 64.
- R2: An accepted word of all zeros yields a count of 0.
- R3: An accepted word of all ones yields a count of 64 (7'b1000000).
- R4: The shift-add reduction (`USE_MUL = 0`) and the multiply reduction (`USE_MUL = 1`) produce identical counts for every input word.
- R5: With `PIPE = 1`, `out_valid` equals `in_valid` from the previous clock edge. `out_count` then reflects the word sampled at that edge.
- R6: With `PIPE = 0`, `out_valid` follows `in_valid` in the same cycle. `out_count` is a combinational function of the present `in_data`.
- R7: With `PIPE = 1`, `out_valid` is low while `rst_n` is low and in the first cycle after reset.
- R8: With `PIPE = 1`, a new word is accepted on every clock edge. Back-to-back valid words each produce their own result in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks `in_data` as a word to count |
| in_data | input | 64 | Word whose set bits are counted |
| out_valid | output | 1 | Marks `out_count` as a result |
| out_count | output | 7 | Number of set bits, 0 to 64 |

## Verification
The input patterns cover several distinct cases, and each one targets a particular class of fault:

- **All zeros and all ones** pin down the two ends of the range. The all-ones word shows whether the carry into bit 6 of the total survives the final truncation.
- **A walking single 1 and a walking single 0** show whether every bit position reaches the total exactly once. A wrong mask or shift amount drops or doubles a lane.
- **Alternating, nibble and byte patterns** load every field of one stage to its maximum at once. They expose a mask applied too late or in the wrong place.
- **Pseudo-random words with gaps in the valid strobe** compare the shift-add and multiply variants, and the registered and combinational builds, against a bit-by-bit count.

// File: rtl/swar_popcount.sv
module swar_popcount #(
  parameter bit USE_MUL = 1'b0,
  parameter int PIPE    = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] in_data,
  output logic        out_valid,
  output logic [6:0]  out_count
);
  localparam int W  = 64;
  localparam int CW = 7;
  localparam logic [W-1:0] PAIR_MASK = {(W/2){2'b01}};
  localparam logic [W-1:0] NIB_MASK  = {(W/4){4'b0011}};
  localparam logic [W-1:0] BYTE_MASK = {(W/8){8'h0f}};
  localparam logic [W-1:0] BYTE_ONES = {(W/8){8'h01}};

  logic [W-1:0] c2, c4, c8, c8_r;
  logic         v_r;
  logic [7:0]   total;

  assign c2 = in_data - ((in_data >> 1) & PAIR_MASK);
  assign c4 = (c2 & NIB_MASK) + ((c2 >> 2) & NIB_MASK);
  assign c8 = (c4 + (c4 >> 4)) & BYTE_MASK;

  generate
    if (PIPE == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_r  <= 1'b0;
          c8_r <= '0;
        end else begin
          v_r  <= in_valid;
          c8_r <= c8;
        end
      end
    end else begin : g_comb
      assign v_r  = in_valid;
      assign c8_r = c8;
    end
  endgenerate

  generate
    if (USE_MUL) begin : g_mul
      logic [W-1:0] prod;
      assign prod  = c8_r * BYTE_ONES;
      assign total = prod[W-1 -: 8];
    end else begin : g_add
      logic [W-1:0] c16, c32, c64;
      assign c16   = c8_r + (c8_r >> 8);
      assign c32   = c16 + (c16 >> 16);
      assign c64   = c32 + (c32 >> 32);
      assign total = c64[7:0];
    end
  endgenerate

  assign out_valid = v_r;
  assign out_count = total[CW-1:0];
endmodule

// File: rtl/swar_popcount_chk.sv
module swar_popcount_chk #(
  parameter bit USE_MUL = 1'b0,
  parameter int PIPE    = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] in_data,
  input logic        out_valid,
  input logic [6:0]  out_count
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  // R1
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_count <= 7'd64);

  generate
    if (PIPE == 1) begin : g_p1
      // R5
      latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> out_valid == $past(in_valid));
      // R1
      count_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && out_valid) |-> out_count == 7'($countones($past(in_data))));
      // R7
      reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !out_valid);
    end else begin : g_p0
      // R6
      latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == in_valid);
      // R1
      count_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_count == 7'($countones(in_data)));
      // R3
      all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data == '1) |-> out_count == 7'd64);
    end
  endgenerate
endmodule

bind swar_popcount swar_popcount_chk #(.USE_MUL(USE_MUL), .PIPE(PIPE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_count(out_count));

// File: tb/tb_swar_popcount.sv
module tb_swar_popcount;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        v_add, v_mul, v_cmb;
  logic [6:0]  c_add, c_mul, c_cmb;
  int checks = 0;
  int errors = 0;
  logic        exp_v = 1'b0;
  int          exp_c = 0;
  logic [63:0] lfsr = 64'h9e37_79b9_7f4a_7c15;

  always #10 clk = ~clk;

  swar_popcount #(.USE_MUL(1'b0), .PIPE(1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(v_add), .out_count(c_add));
  swar_popcount #(.USE_MUL(1'b1), .PIPE(1)) dut_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(v_mul), .out_count(c_mul));
  swar_popcount #(.USE_MUL(1'b1), .PIPE(0)) dut_cmb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(v_cmb), .out_count(c_cmb));

  function automatic int ref_count(logic [63:0] w);
    int n = 0;
    for (int i = 0; i < 64; i++) if (w[i]) n++;
    return n;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(string req, logic v, logic [63:0] d);
    @(negedge clk);
    check("R5 valid", v_add, exp_v);
    check("R4 valid", v_mul, exp_v);
    if (exp_v) begin
      check({req, " R8 shift-add"}, c_add, exp_c);
      check({req, " R4 multiply"}, c_mul, exp_c);
    end
    in_valid = v;
    in_data  = d;
    #1;
    check("R6 valid", v_cmb, v);
    if (v) check({req, " R6 comb"}, c_cmb, ref_count(d));
    exp_v = v;
    exp_c = ref_count(d);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 in reset", v_add, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 after reset", v_add, 0);
    step("R2", 1'b1, 64'h0);
    step("R3", 1'b1, '1);
    step("R2", 1'b1, 64'h0);
    for (int i = 0; i < 64; i++) step("R1 walk1", 1'b1, 64'h1 << i);
    for (int i = 0; i < 64; i++) step("R1 walk0", 1'b1, ~(64'h1 << i));
    step("R1 5s", 1'b1, 64'h5555_5555_5555_5555);
    step("R1 As", 1'b1, 64'haaaa_aaaa_aaaa_aaaa);
    step("R1 33", 1'b1, 64'h3333_3333_3333_3333);
    step("R1 0F", 1'b1, 64'h0f0f_0f0f_0f0f_0f0f);
    step("R1 F0", 1'b1, 64'hf0f0_f0f0_f0f0_f0f0);
    step("R1 FF00", 1'b1, 64'hff00_ff00_ff00_ff00);
    step("R1 hi", 1'b1, 64'hffff_ffff_0000_0000);
    step("R3", 1'b1, '1);
    for (int i = 0; i < 2000; i++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 7);
      lfsr = lfsr ^ (lfsr << 17);
      step("R1 rand", (i % 5) != 3, lfsr);
    end
    step("R5 idle", 1'b0, 64'h0);
    step("R5 idle", 1'b0, '1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule